// File: doc/BRIEF.md
# Prioritized interrupt acknowledge controller

This block handles three interrupt sources of a multi-channel serial controller: receive, transmit and modem. The host programs a 7-bit match level for each source. When the host runs an interrupt-acknowledge cycle, it drives one of these levels on the low address lines. The block compares the address against all three levels in the same cycle. It selects the source being acknowledged and places that source's status byte on an acknowledge data output. If no level matches, the acknowledge is passed on to the next device in the daisy chain.

Each source keeps a status byte. The byte holds three sequence flags (enable, active, end of interrupt), a vector-type field and a channel-number field. A source moves through its sequence as follows:

- A request strobe sets enable and latches the requesting channel's number and vector type.
- A fairness grant strobe sets active, which raises the interrupt request.
- An acknowledge clears enable.
- A host write to the source's end-of-interrupt address clears active. It sets the end-of-interrupt flag if the source was being serviced.

The request strobe and the grant strobe stand in for the channel logic and the fairness arbiter.

Top module: `irq_ack_ctrl`

## Requirements
- R1: Level registers sit at host addresses 0 (receive), 1 (transmit) and 2 (modem). They reset to 0x00 and store bits 6:0 of the written byte. Bit 7 always reads back as 0.
- R2: While `iack_in` is high, a source matches when `ack_addr` equals its level. `ack_sel` is one-hot, with bit 0 for receive, bit 1 for transmit and bit 2 for modem. It is all zero while `iack_in` is low. Bit 7 of a written level plays no part in the comparison.
- R3: When several sources match, receive wins over transmit and transmit wins over modem.
- R4: With `iack_in` high and no match, `iack_out` is 1 and `ack_sel` is 0. `iack_out` is 0 whenever `iack_in` is low or a match exists.
- R5: Status bytes read at addresses 4 (receive), 5 (transmit) and 6 (modem). The layout is: bit 7 enable, bit 6 active, bit 5 end of interrupt, bit 4 always 0, bits 3:2 vector type, bits 1:0 channel number. All status bytes reset to 0x00.
- R6: A `req_start` pulse for an idle source (enable and active both clear) does three things at the next edge: it sets enable, latches `req_chan` and `req_vec`, and clears end of interrupt. The pulse is ignored when the source is not idle.
- R7: A `grant` pulse sets active only when enable is set. `irq` for a source is high exactly while both enable and active are set.
- R8: A selected acknowledge clears that source's enable at the next edge. This drops its `irq`. Active and the latched fields remain unchanged.
- R9: A host write to address 8 (receive), 9 (transmit) or 10 (modem) clears that source's active flag. It sets end of interrupt only if the source was acknowledged while enabled and has had no end-of-interrupt write since.
- R10: Status bytes are read-only: writes to addresses 4 to 6 change nothing. Reads have no side effects.
- R11: `ack_data` carries the selected source's status byte during a matching acknowledge and is 0x00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 4 | Host register address |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data for `reg_addr` |
| req_start | input | 3 | Per-source request-sequence start strobe |
| req_chan | input | 2 | Channel number of the requesting channel |
| req_vec | input | 2 | Vector type of the request |
| grant | input | 3 | Per-source fairness grant strobe |
| iack_in | input | 1 | Interrupt-acknowledge cycle in progress |
| ack_addr | input | 7 | Host address bits compared with the levels |
| iack_out | output | 1 | Acknowledge passed down the chain |
| ack_sel | output | 3 | One-hot acknowledged source |
| ack_data | output | 8 | Status byte of the acknowledged source |
| irq | output | 3 | Per-source interrupt request |

## Verification
Some results are combinational and appear in the same cycle as their stimulus: `ack_sel`, `iack_out`, `ack_data` and `reg_rdata`. The bench drives these inputs after a falling edge and samples one nanosecond later, before any rising edge. Every flag change, latched field and level store takes effect at the first rising edge after the strobe or write. The bench therefore drops each strobe at the following falling edge and reads the status back after that edge. A strobe that should have no effect is judged the same way, by reading the status byte and `irq` one edge later.

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl #(
  parameter int NSRC  = 3,
  parameter int LVL_W = 7,
  parameter int CH_W  = 2,
  parameter int VT_W  = 2,
  parameter int RA_W  = 4,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [RA_W-1:0]  reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [NSRC-1:0]  req_start,
  input  logic [CH_W-1:0]  req_chan,
  input  logic [VT_W-1:0]  req_vec,
  input  logic [NSRC-1:0]  grant,
  input  logic             iack_in,
  input  logic [LVL_W-1:0] ack_addr,
  output logic             iack_out,
  output logic [NSRC-1:0]  ack_sel,
  output logic [DW-1:0]    ack_data,
  output logic [NSRC-1:0]  irq
);
  localparam int ST_BASE  = 4;
  localparam int EOI_BASE = 8;
  localparam int PAD_W    = DW - 3 - VT_W - CH_W;

  logic [NSRC-1:0] hit, en_v, act_v;
  logic [DW-1:0]   lv_v [NSRC];
  logic [DW-1:0]   st_v [NSRC];

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic [LVL_W-1:0] lvl;
    logic             en, act, eoi, svc;
    logic [CH_W-1:0]  ch;
    logic [VT_W-1:0]  vt;
    logic             lvl_wr, eoi_wr, idle;

    assign lvl_wr = reg_wr && (reg_addr == RA_W'(i));
    assign eoi_wr = reg_wr && (reg_addr == RA_W'(EOI_BASE + i));
    assign idle   = !en && !act;
    assign hit[i] = iack_in && (ack_addr == lvl);

    if (i == 0) begin : g_top
      assign ack_sel[i] = hit[i];
    end else begin : g_low
      assign ack_sel[i] = hit[i] && !(|hit[i-1:0]);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lvl <= '0;
        en  <= 1'b0;
        act <= 1'b0;
        eoi <= 1'b0;
        svc <= 1'b0;
        ch  <= '0;
        vt  <= '0;
      end else begin
        if (lvl_wr) lvl <= reg_wdata[LVL_W-1:0];

        if (eoi_wr) begin
          act <= 1'b0;
          svc <= 1'b0;
          if (svc) eoi <= 1'b1;
        end else begin
          if (grant[i] && en) act <= 1'b1;
          if (ack_sel[i] && en) svc <= 1'b1;
        end

        if (req_start[i] && idle) begin
          en  <= 1'b1;
          ch  <= req_chan;
          vt  <= req_vec;
          eoi <= 1'b0;
        end else if (ack_sel[i]) begin
          en <= 1'b0;
        end
      end
    end

    assign en_v[i]  = en;
    assign act_v[i] = act;
    assign lv_v[i]  = {{(DW-LVL_W){1'b0}}, lvl};
    assign st_v[i]  = {en, act, eoi, {PAD_W{1'b0}}, vt, ch};
  end

  assign irq      = en_v & act_v;
  assign iack_out = iack_in && !(|hit);

  always_comb begin
    reg_rdata = '0;
    ack_data  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (reg_addr == RA_W'(i))           reg_rdata = lv_v[i];
      if (reg_addr == RA_W'(ST_BASE + i)) reg_rdata = st_v[i];
      if (ack_sel[i])                     ack_data  = st_v[i];
    end
  end
endmodule

// File: rtl/irq_ack_chk.sv
module irq_ack_chk #(
  parameter int NSRC = 3,
  parameter int RA_W = 4,
  parameter int DW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr,
  input logic [RA_W-1:0] reg_addr,
  input logic [DW-1:0]   reg_rdata,
  input logic [NSRC-1:0] req_start,
  input logic            iack_in,
  input logic            iack_out,
  input logic [NSRC-1:0] ack_sel,
  input logic [NSRC-1:0] irq,
  input logic [NSRC-1:0] en_v,
  input logic [NSRC-1:0] act_v
);
  localparam int EOI_BASE = 8;

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_sel)); // R3
  AST_NO_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !iack_in |-> ack_sel == '0); // R2
  AST_PASS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    iack_out |-> (iack_in && ack_sel == '0)); // R4
  AST_LEVEL_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr < RA_W'(NSRC)) |-> !reg_rdata[DW-1]); // R1
  AST_IRQ_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~act_v) == '0); // R7

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    AST_ACK_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_sel[i] && !req_start[i]) |=> !en_v[i]); // R8
    AST_EOI_CLEARS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == RA_W'(EOI_BASE + i)) |=> !act_v[i]); // R9
  end
endmodule

bind irq_ack_ctrl irq_ack_chk #(.NSRC(NSRC), .RA_W(RA_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .req_start(req_start), .iack_in(iack_in),
  .iack_out(iack_out), .ack_sel(ack_sel), .irq(irq),
  .en_v(en_v), .act_v(act_v)
);

// File: tb/test_irq_ack_ctrl.sv
module test_irq_ack_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [2:0] req_start = '0;
  logic [1:0] req_chan = '0;
  logic [1:0] req_vec = '0;
  logic [2:0] grant = '0;
  logic       iack_in = 1'b0;
  logic [6:0] ack_addr = '0;
  logic       iack_out;
  logic [2:0] ack_sel;
  logic [7:0] ack_data;
  logic [2:0] irq;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_ack_ctrl i_irq_ack_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_start(req_start),
    .req_chan(req_chan), .req_vec(req_vec), .grant(grant),
    .iack_in(iack_in), .ack_addr(ack_addr), .iack_out(iack_out),
    .ack_sel(ack_sel), .ack_data(ack_data), .irq(irq)
  );

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic rd(logic [3:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    reg_addr = a;
    #1 chk(tag, reg_rdata, exp);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic start(int i, logic [1:0] ch, logic [1:0] vt);
    @(negedge clk);
    req_start = 3'(1 << i); req_chan = ch; req_vec = vt;
    @(negedge clk);
    req_start = '0;
  endtask

  task automatic gnt(int i);
    @(negedge clk);
    grant = 3'(1 << i);
    @(negedge clk);
    grant = '0;
  endtask

  task automatic ack(logic [6:0] a, logic [2:0] sel, logic pass, logic [7:0] dat, string tag);
    @(negedge clk);
    iack_in = 1'b1; ack_addr = a;
    #1;
    chk({tag, " sel"}, 8'(ack_sel), 8'(sel));
    chk({tag, " pass"}, 8'(iack_out), 8'(pass));
    chk({tag, " data"}, ack_data, dat);
    @(negedge clk);
    iack_in = 1'b0;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 3; a++) rd(4'(a), 8'h00, "R1 level reset");
    for (int a = 4; a < 7; a++) rd(4'(a), 8'h00, "R5 status reset");
    chk("R7 irq reset", 8'(irq), 8'h00);
    chk("R4 pass idle", 8'(iack_out), 8'h00);
    chk("R2 sel idle", 8'(ack_sel), 8'h00);
  endtask

  task automatic t_levels;
    wr(0, 8'hFF);
    wr(1, 8'h15);
    wr(2, 8'hAA);
    rd(0, 8'h7F, "R1 msb dropped");
    rd(1, 8'h15, "R1 tx level");
    rd(2, 8'h2A, "R1 modem level");
  endtask

  task automatic t_match;
    ack(7'h15, 3'b010, 1'b0, 8'h00, "R2 tx match");
    ack(7'h2A, 3'b100, 1'b0, 8'h00, "R2 modem match msb ignored");
    ack(7'h7F, 3'b001, 1'b0, 8'h00, "R2 rx match");
    ack(7'h33, 3'b000, 1'b1, 8'h00, "R4 no match");
    @(negedge clk);
    ack_addr = 7'h15;
    #1 chk("R4 no iack no pass", 8'(iack_out), 8'h00);
    chk("R2 no iack no sel", 8'(ack_sel), 8'h00);
  endtask

  task automatic t_tie;
    wr(1, 8'h7F);
    ack(7'h7F, 3'b001, 1'b0, 8'h00, "R3 rx over tx");
    wr(0, 8'h10);
    wr(2, 8'h7F);
    ack(7'h7F, 3'b010, 1'b0, 8'h00, "R3 tx over modem");
    wr(1, 8'h11);
    ack(7'h7F, 3'b100, 1'b0, 8'h00, "R3 modem alone");
    wr(2, 8'h12);
  endtask

  task automatic t_flow;
    start(1, 2'd3, 2'd2);
    rd(5, 8'h8B, "R6 start latches fields");
    chk("R7 no irq before grant", 8'(irq), 8'h00);
    gnt(0);
    rd(4, 8'h00, "R7 grant ignored without enable");
    gnt(1);
    rd(5, 8'hCB, "R7 grant sets active");
    chk("R7 irq raised", 8'(irq), 8'h02);
    ack(7'h11, 3'b010, 1'b0, 8'hCB, "R11 ack data");
    rd(5, 8'h4B, "R8 ack clears enable");
    chk("R8 irq dropped", 8'(irq), 8'h00);
    wr(9, 8'h00);
    rd(5, 8'h2B, "R9 eoi after service");
    start(1, 2'd1, 2'd1);
    rd(5, 8'h85, "R6 restart clears eoi");
    start(1, 2'd0, 2'd0);
    rd(5, 8'h85, "R6 start ignored when busy");
    gnt(1);
    rd(5, 8'hC5, "R7 second grant");
    wr(9, 8'h00);
    rd(5, 8'h85, "R9 eoi without service");
    chk("R7 irq off after eoi", 8'(irq), 8'h00);
    start(2, 2'd0, 2'd1);
    rd(6, 8'h84, "R6 modem start");
  endtask

  task automatic t_readonly;
    wr(5, 8'hFF);
    rd(5, 8'h85, "R10 status write ignored");
    wr(6, 8'h00);
    rd(6, 8'h84, "R10 modem write ignored");
    rd(5, 8'h85, "R10 reread unchanged");
    chk("R10 irq unchanged", 8'(irq), 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_levels();
    t_match();
    t_tie();
    t_flow();
    t_readonly();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule